// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block steers four active-low PCI interrupt lines onto a sixteen-bit vector of ISA IRQ requests. Each line carries a four-bit route code held in one of two mapping registers; the code selects one IRQ from a sparse table or disables the line. A separate sensitivity register picks, line by line, whether the request reaches ISA as a held level or as a single-clock pulse on each new assertion.

Software programs the router through a small register bus made of an index, write data, a write strobe and combinational read data. The PCI inputs are asynchronous to the router clock and pass through a synchronizer first. When several lines are routed to the same IRQ, their shaped requests are merged.

Top module: `pirq_steer`

## Requirements
- R1: A write to index 0x42 stores the INT1 code in bits 3:0 and the INT2 code in bits 7:4. A write to index 0x43 stores INT3 in bits 3:0 and INT4 in bits 7:4. Reading either index returns the stored byte.
- R2: Route codes map to IRQs as follows: 1→9, 2→3, 3→10, 4→4, 5→5, 6→7, 7→6, 9→11, 11→12, 13→14, 15→15. An active line raises only its mapped bit of `isa_irq`.
- R3: Code 0 and the reserved codes 8, 10, 12 and 14 drive no IRQ bit.
- R4: Index 0x44 holds the sensitivity bits: bit n-1 controls line INTn, and 1 means edge while 0 means level. A read returns those four bits with bits 7:4 as zero.
- R5: In level mode, the routed IRQ stays high for as long as the synchronized input stays low.
- R6: In edge mode, a falling edge on the input gives a high pulse one clock long on the routed IRQ, and the IRQ then stays low while the input is held low.
- R7: Lines routed to the same IRQ are ORed together.
- R8: Reset clears all three registers to zero, so every line is disabled and in level mode.
- R9: An input change reaches `isa_irq` after the second rising clock edge that follows it, and not after the first.
- R10: A write to any other index changes no register, and a read of any other index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pci_int_n | input | 4 | Active-low PCI interrupt lines; bit 0 is INT1 |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rdata | output | 8 | Read data for `reg_idx` (combinational) |
| isa_irq | output | 16 | Active-high ISA IRQ requests; bit k is IRQk |

## Verification
The assertions run on every cycle. They check that reset clears the configuration, that writes to other indices leave it unchanged, that the upper sensitivity read bits stay zero, that an edge-mode request never lasts two cycles, and that a router holding only disabled or reserved codes stays silent. The bench scenarios are needed for the rest: the exact code-to-IRQ table, nibble placement, the two-edge synchronizer latency, held levels and the merging of shared IRQs. Each of these depends on sequences of input patterns and on comparison against expected IRQ numbers.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int LINES   = 4;
    localparam int IRQS    = 16;
    localparam int IDX_W   = 8;
    localparam int DAT_W   = 8;
    localparam int CODE_W  = 4;
    localparam int NUM_W   = $clog2(IRQS);
    localparam int ROUTE_REGS = LINES / 2;

    localparam logic [IDX_W-1:0] IDX_ROUTE_A = 8'h42;
    localparam logic [IDX_W-1:0] IDX_ROUTE_B = 8'h43;
    localparam logic [IDX_W-1:0] IDX_SENSE   = 8'h44;

    typedef struct packed {
        logic [ROUTE_REGS-1:0][DAT_W-1:0] route;
        logic [LINES-1:0]                 sense;
    } cfg_t;

    typedef struct packed {
        logic             hit;
        logic [NUM_W-1:0] num;
    } target_t;

    function automatic target_t code_to_target(input logic [CODE_W-1:0] code);
        target_t t;
        t.hit = 1'b1;
        t.num = '0;
        case (code)
            4'd1:    t.num = 4'd9;
            4'd2:    t.num = 4'd3;
            4'd3:    t.num = 4'd10;
            4'd4:    t.num = 4'd4;
            4'd5:    t.num = 4'd5;
            4'd6:    t.num = 4'd7;
            4'd7:    t.num = 4'd6;
            4'd9:    t.num = 4'd11;
            4'd11:   t.num = 4'd12;
            4'd13:   t.num = 4'd14;
            4'd15:   t.num = 4'd15;
            default: t.hit = 1'b0;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pirq_shape.sv
module pirq_shape #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] active,
    input  logic [W-1:0] edge_mode,
    output logic [W-1:0] req
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = active;
        for (int i = 0; i < W; i++) begin
            req[i] = edge_mode[i] ? (active[i] & ~prev_q[i]) : active[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_chk
        p_edge_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (req[g] && edge_mode[g]) |=> !(req[g] && edge_mode[g]));
    end
endmodule

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
    import pirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [DAT_W-1:0] wdata,
    input  logic             we,
    output logic [DAT_W-1:0] rdata,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;
    logic idx_known;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (idx)
                IDX_ROUTE_A: cfg_d.route[0] = wdata;
                IDX_ROUTE_B: cfg_d.route[1] = wdata;
                IDX_SENSE:   cfg_d.sense    = wdata[LINES-1:0];
                default: ;
            endcase
        end
        case (idx)
            IDX_ROUTE_A: rdata = cfg_q.route[0];
            IDX_ROUTE_B: rdata = cfg_q.route[1];
            IDX_SENSE:   rdata = {{(DAT_W-LINES){1'b0}}, cfg_q.sense};
            default:     rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
    assign idx_known = (idx == IDX_ROUTE_A) || (idx == IDX_ROUTE_B) || (idx == IDX_SENSE);

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == '0));
    p_foreign_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !idx_known) |=> $stable(cfg_q));
    p_sense_high_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_SENSE) |-> (rdata[DAT_W-1:LINES] == '0));
endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
    import pirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pci_int_n,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [DAT_W-1:0] reg_wdata,
    input  logic             reg_we,
    output logic [DAT_W-1:0] reg_rdata,
    output logic [IRQS-1:0]  isa_irq
);
    cfg_t                         cfg;
    logic [LINES-1:0]             syn_n;
    logic [LINES-1:0]             req;
    logic [LINES-1:0][CODE_W-1:0] code;
    target_t [LINES-1:0]          tgt;
    logic [IRQS-1:0]              irq_d;

    pirq_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .we    (reg_we),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    pirq_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pci_int_n),
        .sync_out (syn_n)
    );

    pirq_shape #(.W(LINES)) u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (~syn_n),
        .edge_mode (cfg.sense),
        .req       (req)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign code[g] = cfg.route[g/2][(g%2)*CODE_W +: CODE_W];
        assign tgt[g]  = code_to_target(code[g]);
    end

    always_comb begin
        irq_d = '0;
        for (int i = 0; i < LINES; i++) begin
            if (req[i] && tgt[i].hit) irq_d[tgt[i].num] = 1'b1;
        end
    end

    assign isa_irq = irq_d;

    logic all_quiet;
    always_comb begin
        all_quiet = 1'b1;
        for (int i = 0; i < LINES; i++) begin
            if (!((code[i] == '0) || (code[i][3] && !code[i][0]))) all_quiet = 1'b0;
        end
    end

    p_reserved_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        all_quiet |-> (isa_irq == '0));
    p_no_irq_without_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_n == '1) |-> (isa_irq == '0));
endmodule

// File: tb/sim_pirq_steer.sv
module sim_pirq_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pci_int_n = 4'hF;
    logic [7:0]  reg_idx = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] isa_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pirq_steer u0 (
        .clk(clk), .rst_n(rst_n), .pci_int_n(pci_int_n),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .isa_irq(isa_irq)
    );

    // {code, expected one-hot IRQ vector} for a held-low INT1 in level mode
    localparam logic [19:0] VEC [16] = '{
        {4'd0,  16'h0000}, {4'd1,  16'h0200}, {4'd2,  16'h0008}, {4'd3,  16'h0400},
        {4'd4,  16'h0010}, {4'd5,  16'h0020}, {4'd6,  16'h0080}, {4'd7,  16'h0040},
        {4'd8,  16'h0000}, {4'd9,  16'h0800}, {4'd10, 16'h0000}, {4'd11, 16'h1000},
        {4'd12, 16'h0000}, {4'd13, 16'h4000}, {4'd14, 16'h0000}, {4'd15, 16'h8000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] data);
        @(negedge clk);
        reg_idx = idx; reg_wdata = data; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [7:0] data);
        reg_idx = idx;
        #1;
        data = reg_rdata;
    endtask

    // drive at a falling edge, then wait for the two synchronizer edges
    task automatic drive_settle(input logic [3:0] v);
        @(negedge clk);
        pci_int_n = v;
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 irq at reset", isa_irq, 16'h0);
        rd(8'h42, d); check("R8 route A reset", {8'h0, d}, 16'h0);
        rd(8'h43, d); check("R8 route B reset", {8'h0, d}, 16'h0);
        rd(8'h44, d); check("R8 sense reset", {8'h0, d}, 16'h0);
        rst_n = 1'b1;

        // R2 R3: decode table walk
        drive_settle(4'b1110);
        for (int k = 0; k < 16; k++) begin
            wr(8'h42, {4'h0, VEC[k][19:16]});
            check($sformatf("R2/R3 code %0d", VEC[k][19:16]), isa_irq, VEC[k][15:0]);
            rd(8'h42, d); check("R1 route A readback", {8'h0, d}, {12'h0, VEC[k][19:16]});
        end
        drive_settle(4'b1111);

        // R1: nibble placement in 0x43
        wr(8'h43, 8'hB5);
        rd(8'h43, d); check("R1 route B readback", {8'h0, d}, 16'h00B5);
        drive_settle(4'b1011);
        check("R1 INT3 low nibble", isa_irq, 16'h0020);
        drive_settle(4'b0011);
        check("R1 INT4 high nibble", isa_irq, 16'h1020);
        drive_settle(4'b1111);
        check("R5 release clears", isa_irq, 16'h0);

        // R4: sensitivity readback
        wr(8'h44, 8'hFA);
        rd(8'h44, d); check("R4 sense readback", {8'h0, d}, 16'h000A);
        wr(8'h44, 8'h00);

        // R9 R5: latency and held level
        wr(8'h42, 8'h02);
        @(negedge clk); pci_int_n = 4'b1110;
        @(posedge clk); @(negedge clk);
        check("R9 one edge not yet", isa_irq, 16'h0);
        @(posedge clk); @(negedge clk);
        check("R9 second edge", isa_irq, 16'h0008);
        repeat (3) @(negedge clk);
        check("R5 level held", isa_irq, 16'h0008);
        drive_settle(4'b1111);

        // R6: edge pulse on INT1
        wr(8'h44, 8'h01);
        @(negedge clk); pci_int_n = 4'b1110;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R6 pulse high", isa_irq, 16'h0008);
        @(negedge clk);
        check("R6 pulse one clock", isa_irq, 16'h0);
        repeat (3) @(negedge clk);
        check("R6 stays low while held", isa_irq, 16'h0);
        drive_settle(4'b1111);
        wr(8'h44, 8'h00);

        // R7: sharing
        wr(8'h42, 8'h55);
        drive_settle(4'b1110);
        check("R7 INT1 on shared", isa_irq, 16'h0020);
        drive_settle(4'b1101);
        check("R7 INT2 on shared", isa_irq, 16'h0020);
        drive_settle(4'b1100);
        check("R7 both on shared", isa_irq, 16'h0020);
        wr(8'h43, 8'h0B);
        drive_settle(4'b1000);
        check("R7 distinct plus shared", isa_irq, 16'h1020);
        drive_settle(4'b1111);

        // R10: foreign index
        wr(8'h45, 8'hFF);
        wr(8'h03, 8'hC5);
        rd(8'h45, d); check("R10 foreign read zero", {8'h0, d}, 16'h0);
        rd(8'h42, d); check("R10 route A unchanged", {8'h0, d}, 16'h0055);
        rd(8'h44, d); check("R10 sense unchanged", {8'h0, d}, 16'h0);

        // R8: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        rd(8'h42, d); check("R8 route A after reset", {8'h0, d}, 16'h0);
        rd(8'h43, d); check("R8 route B after reset", {8'h0, d}, 16'h0);
        rst_n = 1'b1;
        drive_settle(4'b0000);
        check("R8 lines disabled after reset", isa_irq, 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule